// File: doc/BRIEF.md
# Calendar Core with One-Hour Adjustment

This block keeps wall-clock time and date in packed BCD and advances them on a single-cycle 1 Hz enable. Software can load a full time and date. It can also move the running calendar forward or back by exactly one hour with a single command. The hour command never stops the calendar and needs no initialization pass. When it crosses midnight, the day, month and year roll over correctly, including the February length in leap years. A separate flag, owned by software, records that a daylight-saving change was made. The counters never read it.

Commands cross a fixed synchronizer pipeline before they touch the counters. The bus side reads the calendar through shadow copies. A synchronized flag tells software when those copies are current. The flag drops as soon as a write or hour command is accepted. It rises again on the next shadow copy taken after the command has landed. An initialized flag reports whether the year has left its reset value of 00.

Top module: `cal_hour_adj`

## Requirements
- R1: After reset is released, the first clock edge loads the shadows. `rd_time` is 0x000000 and `rd_date` is 0x000101, with `rd_sync`=1, `cal_init`=0 and `bkp_flag`=0.
- R2: Layouts are `rd_time` = {hours[23:16], minutes[15:8], seconds[7:0]} and `rd_date` = {year[23:16], month[15:8], day[7:0]}, all in BCD. Each `tick_1hz` pulse adds one second and carries through minutes (59), hours (23), day, month (12) and year (99 wraps to 00). Hours stay in 00..23 and minutes and seconds in 00..59.
- R3: When `cal_wr` is sampled high at edge E0, the counters take the new time and date at E0+2, with the default of two synchronizer stages. The shadows and `rd_sync`=1 follow at E0+3.
- R4: `hr_add` adds one hour. At hour 23 it wraps to 00 and advances the date by one day, with month and year carry.
- R5: `hr_sub` removes one hour. At hour 00 it wraps to 23 and moves the date back one day. Day 01 borrows from the month, taking that month's last day, and January borrows into December of the previous year, with year 00 becoming 99.
- R6: A year whose value is divisible by 4 gives February 29 days. Other years give it 28. April, June, September and November have 30 days and the other months have 31.
- R7: Asserting `hr_add` and `hr_sub` together leaves the calendar unchanged. Asserting `cal_wr` together with either hour command loads the written value and ignores the hour command.
- R8: `bkp_wr` copies `bkp_wdata` into `bkp_flag` at E0+2. It does not change the calendar and does not clear `rd_sync`.
- R9: `cal_init` is 0 while the year is 00 and 1 while it is non-zero.
- R10: `rd_sync` falls on the edge that samples `cal_wr`, `hr_add` or `hr_sub`. The shadows change only on an edge that leaves `rd_sync` at 1.
- R11: When a second tick arrives on the same edge as an hour command is applied, both take effect: first the second advances, then the hour shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle seconds enable |
| cal_wr | input | 1 | Load calendar command |
| cal_wr_time | input | 24 | BCD time to load {hh,mm,ss} |
| cal_wr_date | input | 24 | BCD date to load {yy,mo,dd} |
| hr_add | input | 1 | Add one hour command |
| hr_sub | input | 1 | Subtract one hour command |
| bkp_wr | input | 1 | Write strobe for the backup flag |
| bkp_wdata | input | 1 | Value for the backup flag |
| rd_time | output | 24 | Shadow copy of time |
| rd_date | output | 24 | Shadow copy of date |
| rd_sync | output | 1 | Shadows are current |
| cal_init | output | 1 | Year is non-zero |
| bkp_flag | output | 1 | Daylight-saving backup flag |

## Verification
The hardest case to reach is a seconds tick landing on the same edge as a delayed hour command. The command is sampled two edges before it is applied, so the tick has to be timed against that hidden pipeline. The bench raises the hour command and holds off the tick for exactly two negative edges, so that the tick meets the command at its apply edge. It then expects both the second and the hour to have moved. The boundary dates are set up directly by calendar writes placed one hour or one second before the crossing. These include a leap-year February end, a 30-day month, and the 00-01-01 to 99-12-31 borrow.

// File: rtl/cal_pkg.sv
// Shared types and BCD calendar arithmetic for the hour-adjust calendar.
// Assumes every stored field holds a valid packed BCD value.
package cal_pkg;

    localparam int DIGIT_W = 4;
    localparam int FIELD_W = 2 * DIGIT_W;

    typedef struct packed {
        logic [FIELD_W-1:0] hh;
        logic [FIELD_W-1:0] mm;
        logic [FIELD_W-1:0] ss;
    } cal_time_t;

    typedef struct packed {
        logic [FIELD_W-1:0] yy;
        logic [FIELD_W-1:0] mo;
        logic [FIELD_W-1:0] dd;
    } cal_date_t;

    typedef struct packed {
        logic      wr;
        logic      add;
        logic      sub;
        logic      bkp_wr;
        logic      bkp_val;
        cal_time_t t;
        cal_date_t d;
    } cal_cmd_t;

    // Increment a two-digit BCD value (caller handles wrap)
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[DIGIT_W-1:0] == 4'd9)
            return {v[FIELD_W-1:DIGIT_W] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Decrement a two-digit BCD value (caller handles wrap)
    function automatic logic [FIELD_W-1:0] bcd_dec(input logic [FIELD_W-1:0] v);
        if (v[DIGIT_W-1:0] == 4'd0)
            return {v[FIELD_W-1:DIGIT_W] - 4'd1, 4'd9};
        return v - 8'd1;
    endfunction

    // Leap year: (10*tens + ones) mod 4 == (2*tens + ones) mod 4
    function automatic logic is_leap(input logic [FIELD_W-1:0] yy);
        logic [1:0] r;
        r = {yy[DIGIT_W], 1'b0} + yy[1:0];
        return (r == 2'b00);
    endfunction

    // Number of days in a month, BCD
    function automatic logic [FIELD_W-1:0] month_days(input logic [FIELD_W-1:0] mo,
                                                      input logic [FIELD_W-1:0] yy);
        case (mo)
            8'h02:                      return is_leap(yy) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Advance a date by one day with month and year carry
    function automatic cal_date_t next_day(input cal_date_t d);
        cal_date_t r;
        r = d;
        if (d.dd == month_days(d.mo, d.yy)) begin
            r.dd = 8'h01;
            if (d.mo == 8'h12) begin
                r.mo = 8'h01;
                r.yy = (d.yy == 8'h99) ? 8'h00 : bcd_inc(d.yy);
            end else begin
                r.mo = bcd_inc(d.mo);
            end
        end else begin
            r.dd = bcd_inc(d.dd);
        end
        return r;
    endfunction

    // Move a date back one day with month and year borrow
    function automatic cal_date_t prev_day(input cal_date_t d);
        cal_date_t r;
        r = d;
        if (d.dd == 8'h01) begin
            if (d.mo == 8'h01) begin
                r.mo = 8'h12;
                r.yy = (d.yy == 8'h00) ? 8'h99 : bcd_dec(d.yy);
            end else begin
                r.mo = bcd_dec(d.mo);
            end
            r.dd = month_days(r.mo, r.yy);
        end else begin
            r.dd = bcd_dec(d.dd);
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_cmd_pipe.sv
// Command synchronizer pipeline: delays every software command by STAGES
// edges before it reaches the counters, and reports calendar commands in flight.
// Assumes STAGES >= 1.
module cal_cmd_pipe
    import cal_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cal_cmd_t cmd_in,
    output cal_cmd_t cmd_out,
    output logic     busy
);

    localparam int LAST = STAGES - 1;

    cal_cmd_t stg [STAGES];

    // Shift commands through the stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= cmd_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    // Flag any calendar-changing command still in the pipe
    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < STAGES; i++)
            busy = busy | stg[i].wr | stg[i].add | stg[i].sub;
    end

    assign cmd_out = stg[LAST];

endmodule

// File: rtl/cal_counter.sv
// Time and date counters. Applies the 1 Hz step first, then a load or an
// hour shift from the synchronized command. Also holds the backup flag.
// Assumes loaded values are valid BCD.
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  cal_cmd_t  app,
    output cal_time_t cnt_t,
    output cal_date_t cnt_d,
    output logic      bkp,
    output logic      upd
);

    cal_time_t t_s, t_n;
    cal_date_t d_s, d_n;

    // Seconds step with carry into minutes, hours and date
    always_comb begin
        t_s = cnt_t;
        d_s = cnt_d;
        if (tick) begin
            if (cnt_t.ss != 8'h59) begin
                t_s.ss = bcd_inc(cnt_t.ss);
            end else begin
                t_s.ss = 8'h00;
                if (cnt_t.mm != 8'h59) begin
                    t_s.mm = bcd_inc(cnt_t.mm);
                end else begin
                    t_s.mm = 8'h00;
                    if (cnt_t.hh != 8'h23) begin
                        t_s.hh = bcd_inc(cnt_t.hh);
                    end else begin
                        t_s.hh = 8'h00;
                        d_s    = next_day(cnt_d);
                    end
                end
            end
        end
    end

    // Load or hour shift on top of the stepped value
    always_comb begin
        t_n = t_s;
        d_n = d_s;
        if (app.wr) begin
            t_n = app.t;
            d_n = app.d;
        end else if (app.add && !app.sub) begin
            if (t_s.hh == 8'h23) begin
                t_n.hh = 8'h00;
                d_n    = next_day(d_s);
            end else begin
                t_n.hh = bcd_inc(t_s.hh);
            end
        end else if (app.sub && !app.add) begin
            if (t_s.hh == 8'h00) begin
                t_n.hh = 8'h23;
                d_n    = prev_day(d_s);
            end else begin
                t_n.hh = bcd_dec(t_s.hh);
            end
        end
    end

    // Calendar and backup flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_t <= '0;
            cnt_d <= '{yy: 8'h00, mo: 8'h01, dd: 8'h01};
            bkp   <= 1'b0;
        end else begin
            cnt_t <= t_n;
            cnt_d <= d_n;
            if (app.bkp_wr) bkp <= app.bkp_val;
        end
    end

    assign upd = tick | app.wr | app.add | app.sub;

endmodule

// File: rtl/cal_shadow.sv
// Bus-side shadow copies with a synchronized flag. Accepting a calendar command
// clears the flag. A copy is taken once no command is in flight and the
// counters have changed since the last copy.
module cal_shadow
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cal_time_t cnt_t,
    input  cal_date_t cnt_d,
    input  logic      upd,
    input  logic      clr_req,
    input  logic      busy,
    output cal_time_t sh_t,
    output cal_date_t sh_d,
    output logic      sync
);

    logic dirty;
    logic take;

    assign take = dirty && !busy && !clr_req;

    // Shadow copy and synchronized flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_t <= '0;
            sh_d <= '0;
            sync <= 1'b0;
        end else if (clr_req) begin
            sync <= 1'b0;
        end else if (take) begin
            sh_t <= cnt_t;
            sh_d <= cnt_d;
            sync <= 1'b1;
        end
    end

    // Track counter changes not yet copied
    always_ff @(posedge clk) begin
        if (!rst_n)    dirty <= 1'b1;
        else if (upd)  dirty <= 1'b1;
        else if (take) dirty <= 1'b0;
    end

endmodule

// File: rtl/cal_hour_adj.sv
// Top of the hour-adjust calendar core: command pipeline, counters and shadows.
// Assumes at most one software command per cycle and valid BCD load data.
module cal_hour_adj
    import cal_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        cal_wr,
    input  logic [23:0] cal_wr_time,
    input  logic [23:0] cal_wr_date,
    input  logic        hr_add,
    input  logic        hr_sub,
    input  logic        bkp_wr,
    input  logic        bkp_wdata,
    output logic [23:0] rd_time,
    output logic [23:0] rd_date,
    output logic        rd_sync,
    output logic        cal_init,
    output logic        bkp_flag
);

    cal_cmd_t  cmd_in, app_cmd;
    cal_time_t cnt_t, sh_t;
    cal_date_t cnt_d, sh_d;
    logic      busy, upd, clr_req;

    // Pack the software inputs into one command word
    always_comb begin
        cmd_in.wr      = cal_wr;
        cmd_in.add     = hr_add;
        cmd_in.sub     = hr_sub;
        cmd_in.bkp_wr  = bkp_wr;
        cmd_in.bkp_val = bkp_wdata;
        cmd_in.t       = cal_wr_time;
        cmd_in.d       = cal_wr_date;
    end

    assign clr_req = cal_wr | hr_add | hr_sub;

    cal_cmd_pipe #(.STAGES(SYNC_STAGES)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_in  (cmd_in),
        .cmd_out (app_cmd),
        .busy    (busy)
    );

    cal_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .app   (app_cmd),
        .cnt_t (cnt_t),
        .cnt_d (cnt_d),
        .bkp   (bkp_flag),
        .upd   (upd)
    );

    cal_shadow u_shd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_t   (cnt_t),
        .cnt_d   (cnt_d),
        .upd     (upd),
        .clr_req (clr_req),
        .busy    (busy),
        .sh_t    (sh_t),
        .sh_d    (sh_d),
        .sync    (rd_sync)
    );

    assign rd_time  = sh_t;
    assign rd_date  = sh_d;
    assign cal_init = (cnt_d.yy != 8'h00);

endmodule

// File: rtl/cal_hour_adj_chk.sv
// Property checker for cal_hour_adj, attached by bind.
module cal_hour_adj_chk
    import cal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        cal_wr,
    input logic        hr_add,
    input logic        hr_sub,
    input logic [23:0] rd_time,
    input logic [23:0] rd_date,
    input logic        rd_sync,
    input logic        cal_init,
    input logic        bkp_flag,
    input cal_cmd_t    app_cmd,
    input cal_time_t   cnt_t
);

    assert_sync_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_wr || hr_add || hr_sub) |=> !rd_sync);

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(rd_time) && $stable(rd_date)) |-> rd_sync);

    assert_bkp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bkp_flag) |-> $past(app_cmd.bkp_wr));

    assert_time_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_t.hh <= 8'h23) && (cnt_t.mm <= 8'h59) && (cnt_t.ss <= 8'h59));

    assert_init_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_init) |-> $past(app_cmd.wr || app_cmd.add || app_cmd.sub || tick_1hz));

endmodule

bind cal_hour_adj cal_hour_adj_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .cal_wr   (cal_wr),
    .hr_add   (hr_add),
    .hr_sub   (hr_sub),
    .rd_time  (rd_time),
    .rd_date  (rd_date),
    .rd_sync  (rd_sync),
    .cal_init (cal_init),
    .bkp_flag (bkp_flag),
    .app_cmd  (app_cmd),
    .cnt_t    (cnt_t)
);

// File: tb/sim_cal_hour_adj.sv
// Scoreboard bench: drivers queue expected shadow values, a monitor compares them
// once rd_sync is high.
module sim_cal_hour_adj;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        cal_wr = 1'b0;
    logic [23:0] cal_wr_time = '0;
    logic [23:0] cal_wr_date = '0;
    logic        hr_add = 1'b0;
    logic        hr_sub = 1'b0;
    logic        bkp_wr = 1'b0;
    logic        bkp_wdata = 1'b0;
    logic [23:0] rd_time, rd_date;
    logic        rd_sync, cal_init, bkp_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    cal_hour_adj u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .cal_wr(cal_wr), .cal_wr_time(cal_wr_time), .cal_wr_date(cal_wr_date),
        .hr_add(hr_add), .hr_sub(hr_sub), .bkp_wr(bkp_wr), .bkp_wdata(bkp_wdata),
        .rd_time(rd_time), .rd_date(rd_date), .rd_sync(rd_sync),
        .cal_init(cal_init), .bkp_flag(bkp_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare when the shadows are valid
    always @(negedge clk) begin
        if (exp_q.size() != 0 && rd_sync) begin
            logic [47:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({rd_time, rd_date} == e, t, {rd_time, rd_date}, e);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Issue a write and/or hour command and queue the expected shadow
    task automatic do_cmd(input logic wr, input logic add, input logic sub,
                          input logic [23:0] t, input logic [23:0] d,
                          input logic [47:0] exp, input string tag);
        @(negedge clk);
        cal_wr = wr; hr_add = add; hr_sub = sub; cal_wr_time = t; cal_wr_date = d;
        @(negedge clk);
        cal_wr = 1'b0; hr_add = 1'b0; hr_sub = 1'b0;
        chk(rd_sync == 1'b0, "R10 sync drops on accept", {47'd0, rd_sync}, 48'd0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        @(negedge clk);
        chk(rd_sync == 1'b0, "R3 sync still low at E0+2", {47'd0, rd_sync}, 48'd0);
        @(negedge clk);
        chk(rd_sync == 1'b1, "R3 sync high at E0+3", {47'd0, rd_sync}, 48'd1);
        wait_drain();
    endtask

    task automatic do_tick(input int n, input logic [47:0] exp, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        wait_drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({rd_time, rd_date} == 48'h000000_000101, "R1 reset calendar",
            {rd_time, rd_date}, 48'h000000_000101);
        chk({rd_sync, cal_init, bkp_flag} == 3'b100, "R1 reset flags",
            {45'd0, rd_sync, cal_init, bkp_flag}, 48'd4);

        // R3 load, R9 init set
        do_cmd(1, 0, 0, 24'h235958, 24'h991231, 48'h235958_991231, "R3 write load");
        chk(cal_init == 1'b1, "R9 init after year 99", {47'd0, cal_init}, 48'd1);

        // R2 ticks with full rollover
        do_tick(1, 48'h235959_991231, "R2 tick seconds");
        do_tick(1, 48'h000000_000101, "R2 tick year wrap");
        chk(cal_init == 1'b0, "R9 init clear at year 00", {47'd0, cal_init}, 48'd0);

        do_cmd(1, 0, 0, 24'h105959, 24'h210630, 48'h105959_210630, "R3 write");
        do_tick(1, 48'h110000_210630, "R2 tick minute/hour carry");

        // R4 add hour
        do_cmd(1, 0, 0, 24'h123045, 24'h240228, 48'h123045_240228, "R3 write");
        do_cmd(0, 1, 0, 24'h0, 24'h0, 48'h133045_240228, "R4 add hour plain");
        do_cmd(1, 0, 0, 24'h231000, 24'h240228, 48'h231000_240228, "R3 write");
        do_cmd(0, 1, 0, 24'h0, 24'h0, 48'h001000_240229, "R4 R6 add into leap day");
        do_cmd(1, 0, 0, 24'h230000, 24'h230228, 48'h230000_230228, "R3 write");
        do_cmd(0, 1, 0, 24'h0, 24'h0, 48'h000000_230301, "R4 R6 add non-leap month carry");

        // R5 subtract hour
        do_cmd(1, 0, 0, 24'h002000, 24'h240301, 48'h002000_240301, "R3 write");
        do_cmd(0, 0, 1, 24'h0, 24'h0, 48'h232000_240229, "R5 R6 sub into leap Feb");
        do_cmd(1, 0, 0, 24'h000000, 24'h210501, 48'h000000_210501, "R3 write");
        do_cmd(0, 0, 1, 24'h0, 24'h0, 48'h230000_210430, "R5 sub into 30-day month");
        do_cmd(1, 0, 0, 24'h000500, 24'h000101, 48'h000500_000101, "R3 write");
        do_cmd(0, 0, 1, 24'h0, 24'h0, 48'h230500_991231, "R5 sub year borrow");
        chk(cal_init == 1'b1, "R9 init after borrow", {47'd0, cal_init}, 48'd1);
        do_cmd(0, 0, 1, 24'h0, 24'h0, 48'h220500_991231, "R5 sub plain");

        // R7 conflicts
        do_cmd(0, 1, 1, 24'h0, 24'h0, 48'h220500_991231, "R7 add+sub no change");
        do_cmd(1, 1, 0, 24'h100000, 24'h210630, 48'h100000_210630, "R7 write beats add");

        // R11 tick meets applied hour command
        do_cmd(1, 0, 0, 24'h095959, 24'h210630, 48'h095959_210630, "R3 write");
        @(negedge clk); hr_add = 1'b1;
        @(negedge clk); hr_add = 1'b0;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        exp_q.push_back(48'h110000_210630);
        tag_q.push_back("R11 tick plus add same edge");
        wait_drain();

        // R8 backup flag
        @(negedge clk); bkp_wr = 1'b1; bkp_wdata = 1'b1;
        @(negedge clk); bkp_wr = 1'b0;
        @(negedge clk);
        chk(bkp_flag == 1'b0, "R8 bkp not yet at E0+1", {47'd0, bkp_flag}, 48'd0);
        @(negedge clk);
        chk(bkp_flag == 1'b1, "R8 bkp set at E0+2", {47'd0, bkp_flag}, 48'd1);
        chk(rd_sync == 1'b1, "R8 sync kept", {47'd0, rd_sync}, 48'd1);
        repeat (3) @(negedge clk);
        chk({rd_time, rd_date} == 48'h110000_210630, "R8 calendar untouched",
            {rd_time, rd_date}, 48'h110000_210630);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule